// File: doc/BRIEF.md
# Edge-Interval Bit-Check Validator

This block decides whether a demodulated serial bit stream comes from a genuine transmitter or from noise. After a start pulse, it waits through a warm-up period. During that period the demodulator output is not trusted, so any edges are discarded. It then measures the spacing between successive data edges in units of an external timebase tick. Rising and falling edges are treated alike.

Each interval must land inside a programmable window. An interval that ends too early aborts the run with a fail indication. So does an interval that grows to the upper bound, and in that case the fail is raised on that tick rather than on the next edge. When the selected number of consecutive intervals all pass, a pass indication tells the surrounding sequencer to enter receive mode. A fail tells it to go back to sleep. Both results are held until the next start pulse.

The data input is resynchronised inside the block. The limits and the run length are captured at the start pulse, so they may change freely while a run is in progress.

Top module: `edge_window_checker`

## Requirements
- R1: After reset, `pass_o`, `fail_o` and `busy_o` are all low.
- R2: A `start_i` pulse clears `pass_o` and `fail_o`, raises `busy_o` and captures `lo_lim_i`, `hi_lim_i` and `bits_sel_i`. Later changes on those inputs do not affect the running check.
- R3: For the first STARTUP_TICKS timebase ticks after start, data edges are ignored and cannot produce a pass or a fail.
- R4: The first edge after the warm-up is not judged. It only zeroes the interval count and begins checking.
- R5: The interval count is the number of ticks since the previous accepted edge. An edge whose count is at least the lower limit and below the upper limit is a good check, for either edge polarity, and checking continues.
- R6: An edge whose count is below the lower limit raises `fail_o` and ends the run.
- R7: A tick that would bring the count up to the upper limit raises `fail_o` on that tick, without waiting for an edge. With an upper limit of H, H-1 ticks without an edge are still tolerated.
- R8: `bits_sel_i` codes 0, 1, 2 and 3 require 0, 6, 12 and 18 consecutive good checks. `pass_o` rises on the last of them. With code 0, `pass_o` rises at the end of the warm-up without any edge.
- R9: A lower-limit value below 10 is treated as 10.
- R10: When an edge and a tick fall in the same cycle, the edge is judged against the count before that tick.
- R11: `pass_o` and `fail_o` are never high together. Once either is high it stays high until the next `start_i`, and edges and ticks in between have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a new check run |
| tick_i | input | 1 | One-cycle timebase strobe that advances the interval count |
| rx_data_i | input | 1 | Demodulated data bit (asynchronous) |
| lo_lim_i | input | 6 | Lower interval limit in ticks |
| hi_lim_i | input | 6 | Upper interval limit in ticks |
| bits_sel_i | input | 2 | Run-length code (0/3/6/9 bits) |
| pass_o | output | 1 | Run succeeded; held until next start |
| fail_o | output | 1 | Run failed; held until next start |
| busy_o | output | 1 | Warm-up or checking in progress |

## Verification
Two things can fall in the same cycle: a synchronised data edge being judged, and a timebase tick that would push the count to the upper limit. The bench provokes this by placing a tick on exactly the cycle in which the resynchronised edge is presented, with the count already at the upper limit minus one. It expects the edge to be judged as a good check, so the final check of that run yields `pass_o` with `fail_o` low. Intervals of exactly the lower limit and of the upper limit minus one are also run, to pin down both sides of the window.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  localparam int RUN_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WARM  = 3'd1,
    ST_ARM   = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } ewc_state_t;

  // Two edge checks per bit; codes 0..3 select 0,3,6,9 bits.
  function automatic logic [RUN_W-1:0] checks_needed(input logic [1:0] sel);
    return {3'b000, sel} * 5'd6;
  endfunction

endpackage

// File: rtl/ewc_edge_sync.sv
module ewc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = din_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], din_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/ewc_warm_timer.sv
module ewc_warm_timer #(
  parameter int STARTUP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int TW = $clog2(STARTUP_TICKS + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (en_i && tick_i);
    cnt_d  = clr_i ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = en_i && tick_i && (cnt_q == TW'(STARTUP_TICKS - 1));

  AST_WARM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < TW'(STARTUP_TICKS))); // R3

endmodule

// File: rtl/ewc_interval_ctr.sv
module ewc_interval_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/ewc_ctrl.sv
module ewc_ctrl
  import ewc_pkg::*;
#(
  parameter int LIM_W    = 6,
  parameter int LO_FLOOR = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic [LIM_W-1:0] lo_i,
  input  logic [LIM_W-1:0] hi_i,
  input  logic [1:0]       sel_i,
  input  logic             warm_done_i,
  input  logic [LIM_W-1:0] cnt_i,
  output logic             warm_en_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o
);

  localparam logic [LIM_W-1:0] FLOOR_V = LIM_W'(LO_FLOOR);

  ewc_state_t       state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] need_q;
  logic [LIM_W-1:0] lo_q, hi_q;
  logic             pass_q, pass_d;
  logic             fail_q, fail_d;

  logic too_short;
  logic too_long;
  logic hit_hi;
  logic last_check;

  always_comb begin
    too_short  = cnt_i < lo_q;
    too_long   = cnt_i >= hi_q;
    hit_hi     = ({1'b0, cnt_i} + {{LIM_W{1'b0}}, 1'b1}) == {1'b0, hi_q};
    last_check = (run_q + RUN_W'(1)) == need_q;
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    run_d     = run_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    warm_en_o = 1'b0;
    if (start_i) begin
      state_d   = ST_WARM;
      run_d     = '0;
      pass_d    = 1'b0;
      fail_d    = 1'b0;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_WARM: begin
          warm_en_o = 1'b1;
          if (warm_done_i) begin
            if (need_q == '0) begin
              state_d = ST_DONE;
              pass_d  = 1'b1;
            end else begin
              state_d = ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (edge_i) begin
            cnt_clr_o = 1'b1;
            state_d   = ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (edge_i) begin
            // edge judged on the count before any same-cycle tick
            if (too_short || too_long) begin
              state_d = ST_DONE;
              fail_d  = 1'b1;
            end else if (last_check) begin
              state_d = ST_DONE;
              pass_d  = 1'b1;
            end else begin
              run_d     = run_q + RUN_W'(1);
              cnt_clr_o = 1'b1;
            end
          end else if (tick_i) begin
            if (hit_hi) begin
              state_d = ST_DONE;
              fail_d  = 1'b1;
            end else begin
              cnt_inc_o = 1'b1;
            end
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  // configuration capture, enabled by start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= FLOOR_V;
      hi_q   <= '1;
      need_q <= '0;
    end else if (start_i) begin
      lo_q   <= (lo_i < FLOOR_V) ? FLOOR_V : lo_i;
      hi_q   <= hi_i;
      need_q <= checks_needed(sel_i);
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign busy_o = (state_q == ST_WARM) || (state_q == ST_ARM) || (state_q == ST_CHECK);

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q)); // R11

  AST_RESULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pass_q || fail_q) && !start_i) |=> ($stable(pass_q) && $stable(fail_q))); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !pass_q && !fail_q)); // R2

  AST_SHORT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && edge_i && !start_i && cnt_i < lo_q) |=> fail_q); // R6

  AST_REACH_HI_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && tick_i && !edge_i && !start_i &&
     (cnt_i == hi_q - LIM_W'(1)) && hi_q != '0) |=> fail_q); // R7

  AST_LO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q >= FLOOR_V); // R9

  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!pass_q && !fail_q)); // R11

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |-> (run_q < need_q)); // R8

endmodule

// File: rtl/edge_window_checker.sv
module edge_window_checker #(
  parameter int LIM_W         = 6,
  parameter int LO_FLOOR      = 10,
  parameter int STARTUP_TICKS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             rx_data_i,
  input  logic [LIM_W-1:0] lo_lim_i,
  input  logic [LIM_W-1:0] hi_lim_i,
  input  logic [1:0]       bits_sel_i,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             edge_w;
  logic             warm_done_w;
  logic             warm_en_w;
  logic             cnt_clr_w;
  logic             cnt_inc_w;
  logic [LIM_W-1:0] cnt_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ewc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .din_i  (rx_data_i),
    .edge_o (edge_w)
  );

  ewc_warm_timer #(.STARTUP_TICKS(STARTUP_TICKS)) u_warm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (start_i),
    .en_i   (warm_en_w),
    .tick_i (tick_i),
    .done_o (warm_done_w)
  );

  ewc_interval_ctr #(.W(LIM_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (cnt_clr_w),
    .inc_i (cnt_inc_w),
    .cnt_o (cnt_w)
  );

  ewc_ctrl #(.LIM_W(LIM_W), .LO_FLOOR(LO_FLOOR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .edge_i      (edge_w),
    .lo_i        (lo_lim_i),
    .hi_i        (hi_lim_i),
    .sel_i       (bits_sel_i),
    .warm_done_i (warm_done_w),
    .cnt_i       (cnt_w),
    .warm_en_o   (warm_en_w),
    .cnt_clr_o   (cnt_clr_w),
    .cnt_inc_o   (cnt_inc_w),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .busy_o      (busy_o)
  );

endmodule

// File: tb/edge_window_checker_bench.sv
`timescale 1ns/1ps
module edge_window_checker_bench;

  localparam int STARTUP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_data_i = 1'b0;
  logic [5:0] lo_lim_i = 6'd10;
  logic [5:0] hi_lim_i = 6'd20;
  logic [1:0] bits_sel_i = 2'd0;
  logic       pass_o, fail_o, busy_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  edge_window_checker #(.STARTUP_TICKS(STARTUP)) u_edge_window_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .rx_data_i  (rx_data_i),
    .lo_lim_i   (lo_lim_i),
    .hi_lim_i   (hi_lim_i),
    .bits_sel_i (bits_sel_i),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .busy_o     (busy_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic p, input logic f, input logic b);
    check({tag, " pass"}, pass_o, p);
    check({tag, " fail"}, fail_o, f);
    check({tag, " busy"}, busy_o, b);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic toggle();
    @(negedge clk) rx_data_i = ~rx_data_i;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_good(input int n, input int ticks);
    for (int i = 0; i < n; i++) begin
      give_ticks(ticks);
      toggle();
    end
  endtask

  task automatic begin_run(input logic [5:0] lo, input logic [5:0] hi, input logic [1:0] sel);
    @(negedge clk);
    lo_lim_i = lo; hi_lim_i = hi; bits_sel_i = sel; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic t_reset();
    check_out("R1 reset", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sel_zero();
    begin_run(6'd10, 6'd20, 2'd0);
    check_out("R2 start", 1'b0, 1'b0, 1'b1);
    give_ticks(STARTUP - 1);
    check_out("R3 warmup not over", 1'b0, 1'b0, 1'b1);
    give_ticks(1);
    check_out("R8 code0 pass", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_warm_and_six();
    begin_run(6'd10, 6'd20, 2'd1);
    lo_lim_i = 6'd40; hi_lim_i = 6'd2; bits_sel_i = 2'd0; // R2 ignored after start
    give_ticks(1); toggle(); give_ticks(1); toggle(); give_ticks(2);
    check_out("R3 warmup edges ignored", 1'b0, 1'b0, 1'b1);
    give_ticks(2);
    toggle(); // R4 first edge only arms, count would be short
    check_out("R4 first edge unchecked", 1'b0, 1'b0, 1'b1);
    run_good(1, 10); // R5 exactly lower limit
    run_good(1, 19); // R5 upper limit minus one
    run_good(3, 14);
    check_out("R8 five of six", 1'b0, 1'b0, 1'b1);
    run_good(1, 12);
    check_out("R5 six good checks pass", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_short();
    begin_run(6'd10, 6'd20, 2'd2);
    give_ticks(STARTUP); toggle();
    run_good(1, 12);
    give_ticks(9); toggle();
    check_out("R6 short interval", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_long_and_sticky();
    begin_run(6'd10, 6'd20, 2'd3);
    give_ticks(STARTUP); toggle();
    give_ticks(19);
    check_out("R7 hi-1 ticks tolerated", 1'b0, 1'b0, 1'b1);
    give_ticks(1);
    check_out("R7 reach upper limit", 1'b0, 1'b1, 1'b0);
    give_ticks(12); toggle(); give_ticks(12); toggle();
    check_out("R11 result sticky", 1'b0, 1'b1, 1'b0);
    begin_run(6'd10, 6'd20, 2'd3);
    check_out("R2 restart clears", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_floor();
    begin_run(6'd3, 6'd20, 2'd1);
    give_ticks(STARTUP); toggle();
    give_ticks(5); toggle();
    check_out("R9 low limit floored", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_lengths();
    begin_run(6'd10, 6'd20, 2'd2);
    give_ticks(STARTUP); toggle();
    run_good(11, 11);
    check_out("R8 code2 eleven", 1'b0, 1'b0, 1'b1);
    run_good(1, 11);
    check_out("R8 code2 twelve", 1'b1, 1'b0, 1'b0);
    begin_run(6'd10, 6'd20, 2'd3);
    give_ticks(STARTUP); toggle();
    run_good(17, 15);
    check_out("R8 code3 seventeen", 1'b0, 1'b0, 1'b1);
    run_good(1, 15);
    check_out("R8 code3 eighteen", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_collision();
    begin_run(6'd10, 6'd20, 2'd1);
    give_ticks(STARTUP); toggle();
    run_good(5, 13);
    give_ticks(19);
    // R10: edge presented in the same cycle as the tick that reaches the limit
    @(negedge clk) rx_data_i = ~rx_data_i;
    @(negedge clk);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R10 edge beats tick", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sel_zero();
    t_warm_and_six();
    t_short();
    t_long_and_sticky();
    t_floor();
    t_lengths();
    t_collision();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule